// File: doc/BRIEF.md
# Pulse-Width Coded Serial Transceiver

This block drives and receives a single-wire serial line with an open-drain stage. Every bit starts when the line is pulled low. The value of a bit depends only on how long the line stays low inside a fixed bit period. The transmitter takes a byte and a one-cycle start request. It then sends a start bit, which is longer than a data bit, followed by eight data bits, most significant bit first. The block does not drive the high level. It only asserts a pull-down enable, and an external resistor pulls the line high.

The receiver passes the line level through a synchroniser and watches for falling edges. A low phase longer than one data-bit period marks the start of a frame. After that, the receiver restarts its timing at every falling edge and samples the line a fixed delay later to decide each bit. Because it resynchronises on each bit, a peer whose bit period drifts slightly is still decoded. When the expected next edge does not arrive in time, the receiver reports a framing error.

All timing is counted in clock cycles and comes from one parameter, `BIT_T`, the data-bit period. The other times derive from it:
- short low: BIT_T/3
- long low: 2·BIT_T/3
- sample point: BIT_T/2
- start period: 2·BIT_T
- start low: 3/4 of the start period

Top module: `pwc_link`

## Requirements
- R1: When the transmitter is idle and `tx_start` is high at a clock edge, `tx_busy` is high from the next cycle and `line_pull` is high in that same cycle.
- R2: The start bit keeps `line_pull` high for 3·BIT_T/2 cycles (18 at the default) within a period of 2·BIT_T cycles (24).
- R3: The eight data bits follow the start bit, bit 7 first. Each data bit has a period of BIT_T cycles. A 1 holds the line low for 2·BIT_T/3 cycles (8) and a 0 for BIT_T/3 cycles (4).
- R4: `line_pull` high means the line is driven low. `line_pull` is never high while `tx_busy` is low.
- R5: At the end of the last data-bit period, `tx_done` is high for exactly one cycle and `tx_busy` falls in that same cycle. From the first pulled cycle to `tx_done`, a frame takes 10·BIT_T cycles.
- R6: A `tx_start` while `tx_busy` is high has no effect on the frame being sent and does not queue a second frame.
- R7: While the receiver is idle, a low phase of BIT_T cycles or fewer is ignored and produces neither `rx_valid` nor `rx_err`. A low phase longer than BIT_T cycles starts a frame.
- R8: The receiver samples the line BIT_T/2 cycles after each synchronised falling edge and reads a low level as 1. After the eighth bit it pulses `rx_valid` for one cycle, with the byte on `rx_data` (first bit received in bit 7).
- R9: Decoding stays correct when the peer's data-bit period differs from BIT_T by one cycle, because timing restarts at every falling edge.
- R10: Inside a frame, if no falling edge arrives within the current bit's period plus BIT_T/2 cycles, `rx_err` pulses for one cycle. No `rx_valid` follows for that frame, and the receiver returns to idle ready for a new frame.
- R11: After reset, `line_pull`, `tx_busy`, `tx_done`, `rx_valid` and `rx_err` are low. `rx_valid` and `rx_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 8 | Byte to send, captured with an accepted start request |
| tx_start | input | 1 | Start request, taken only while idle |
| tx_busy | output | 1 | Frame being sent |
| tx_done | output | 1 | One-cycle pulse when a frame ends |
| line_pull | output | 1 | Pull-down enable for the open-drain line |
| line_in | input | 1 | Level read from the line |
| rx_data | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new byte |
| rx_err | output | 1 | One-cycle pulse: framing timeout |

## Verification
The assertions assume that `line_in` shows a line that is low whenever `line_pull` is high. This holds because the bench models the wire as the AND of the block's own pull and a second open-drain driver. They also assume that `tx_start` can arrive in any cycle, busy or not. The bench uses the second driver only while the transmitter is idle. With it, the bench plays the role of a peer: it sends frames with shifted periods, lows just below and just above the start threshold, and frames cut short.

// File: rtl/pwc_link.sv
module pwc_link #(
  parameter int BIT_T = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_data,
  input  logic       tx_start,
  output logic       tx_busy,
  output logic       tx_done,
  output logic       line_pull,
  input  logic       line_in,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_err
);
  localparam int START_T   = 2 * BIT_T;
  localparam int START_LOW = (3 * START_T) / 4;
  localparam int ONE_LOW   = (2 * BIT_T) / 3;
  localparam int ZERO_LOW  = BIT_T / 3;
  localparam int SAMPLE_AT = BIT_T / 2;
  localparam int SLACK     = BIT_T / 2;
  localparam int CW        = $clog2(3 * BIT_T + 1);

  // transmitter
  logic          tx_run;
  logic [3:0]    tx_idx;
  logic [CW-1:0] tx_cnt;
  logic [7:0]    tx_sh;

  wire           tx_first = (tx_idx == 4'd0);
  wire  [CW-1:0] tx_low   = tx_first ? CW'(START_LOW) : (tx_sh[7] ? CW'(ONE_LOW) : CW'(ZERO_LOW));
  wire           tx_end   = tx_cnt == (tx_first ? CW'(START_T - 1) : CW'(BIT_T - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_run  <= 1'b0;
      tx_idx  <= '0;
      tx_cnt  <= '0;
      tx_sh   <= '0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (!tx_run) begin
        if (tx_start) begin
          tx_run <= 1'b1;
          tx_idx <= '0;
          tx_cnt <= '0;
          tx_sh  <= tx_data;
        end
      end else if (tx_end) begin
        tx_cnt <= '0;
        if (tx_idx == 4'd8) begin
          tx_run  <= 1'b0;
          tx_done <= 1'b1;
        end else begin
          tx_idx <= tx_idx + 4'd1;
          if (!tx_first) tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  assign tx_busy   = tx_run;
  assign line_pull = tx_run && (tx_cnt < tx_low);

  // receiver
  typedef enum logic [1:0] {RX_IDLE, RX_QUAL, RX_GAP, RX_SMP} rx_st_t;

  rx_st_t        rx_st;
  logic [2:0]    rx_s;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_n;
  logic [7:0]    rx_sh;
  logic          rx_first;

  wire           rx_lvl  = rx_s[1];
  wire           rx_fall = rx_s[2] & ~rx_s[1];
  wire  [CW-1:0] rx_lim  = rx_first ? CW'(START_T + SLACK) : CW'(BIT_T + SLACK);
  wire  [7:0]    rx_next = {rx_sh[6:0], ~rx_lvl};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s     <= 3'b111;
      rx_st    <= RX_IDLE;
      rx_cnt   <= '0;
      rx_n     <= '0;
      rx_sh    <= '0;
      rx_first <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      rx_s     <= {rx_s[1:0], line_in};
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      unique case (rx_st)
        RX_IDLE: if (rx_fall) begin
          rx_cnt <= CW'(1);
          rx_st  <= RX_QUAL;
        end
        RX_QUAL: begin
          rx_cnt <= rx_cnt + 1'b1;
          if (rx_lvl) rx_st <= RX_IDLE;
          else if (rx_cnt == CW'(BIT_T)) begin
            rx_st    <= RX_GAP;
            rx_first <= 1'b1;
            rx_n     <= '0;
          end
        end
        RX_GAP: begin
          rx_cnt <= rx_cnt + 1'b1;
          if (rx_fall) begin
            rx_cnt <= CW'(1);
            rx_st  <= RX_SMP;
          end else if (rx_cnt >= rx_lim) begin
            rx_err <= 1'b1;
            rx_st  <= RX_IDLE;
          end
        end
        RX_SMP: begin
          rx_cnt <= rx_cnt + 1'b1;
          if (rx_cnt == CW'(SAMPLE_AT)) begin
            rx_sh    <= rx_next;
            rx_first <= 1'b0;
            if (rx_n == 4'd7) begin
              rx_data  <= rx_next;
              rx_valid <= 1'b1;
              rx_st    <= RX_IDLE;
            end else begin
              rx_n  <= rx_n + 4'd1;
              rx_st <= RX_GAP;
            end
          end
        end
        default: rx_st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwc_link_chk.sv
module pwc_link_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_start,
  input logic tx_busy,
  input logic tx_done,
  input logic line_pull,
  input logic rx_valid,
  input logic rx_err
);
  assert_start_pulls_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && tx_start) |=> (tx_busy && line_pull));

  assert_idle_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !line_pull);

  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!tx_busy && $past(tx_busy)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  assert_busy_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_start) |=> (tx_busy || tx_done));

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> !rx_err);

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_err));
endmodule

bind pwc_link pwc_link_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_busy(tx_busy),
  .tx_done(tx_done), .line_pull(line_pull), .rx_valid(rx_valid), .rx_err(rx_err)
);

// File: tb/pwc_link_tb_top.sv
`timescale 1ns/1ps
module pwc_link_tb_top;
  localparam int BT = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] tx_data = 0;
  logic tx_start = 0;
  logic ext_pull = 0;
  logic tx_busy, tx_done, line_pull, rx_valid, rx_err;
  logic [7:0] rx_data;
  wire line_in = ~(line_pull | ext_pull);

  always #2 clk = ~clk;

  pwc_link #(.BIT_T(BT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_start(tx_start),
    .tx_busy(tx_busy), .tx_done(tx_done), .line_pull(line_pull),
    .line_in(line_in), .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err)
  );

  int checks = 0, errors = 0;
  int cyc = 0, n_valid = 0, n_err = 0, n_done = 0, done_t = 0, ek = 0;
  int pull_t[16], rel_t[16];
  logic [7:0] last_rx = 0;
  logic prev_pull = 0;
  bit finished = 0;

  always @(negedge clk) begin
    cyc++;
    if (rx_valid) begin n_valid++; last_rx = rx_data; end
    if (rx_err) n_err++;
    if (tx_done) begin n_done++; done_t = cyc; end
    if (rx_valid && rx_err) begin
      errors++;
      $display("FAIL R11: rx_valid and rx_err both high (got 1, expected 0)");
    end
    if (line_pull && !prev_pull && ek < 16) pull_t[ek] = cyc;
    if (!line_pull && prev_pull && ek < 16) begin rel_t[ek] = cyc; ek++; end
    prev_pull = line_pull;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit poke_busy);
    int v0, d0, guard;
    v0 = n_valid; d0 = n_done; ek = 0;
    @(negedge clk); tx_data = b; tx_start = 1;
    @(negedge clk); tx_start = 0;
    if (poke_busy) begin
      wait_cyc(30);
      tx_data = ~b; tx_start = 1;
      @(negedge clk); tx_start = 0; tx_data = 8'h00;
    end
    guard = 0;
    while (n_done == d0 && guard < 400) begin @(negedge clk); guard++; end
    wait_cyc(10);
    chk("R8 valid count", n_valid - v0, 1);
    chk("R8 data", int'(last_rx), int'(b));
  endtask

  task automatic drive_bit(input int low, input int per);
    ext_pull = 1;
    for (int i = 0; i < low; i++) @(negedge clk);
    ext_pull = 0;
    for (int i = low; i < per; i++) @(negedge clk);
  endtask

  task automatic ext_frame(input logic [7:0] b, input int per, input int nbits);
    @(negedge clk);
    drive_bit(3 * BT / 2, 2 * BT);
    for (int i = 0; i < nbits; i++)
      drive_bit(b[7 - i] ? (2 * per) / 3 : per / 3, per);
  endtask

  task automatic timing_frame(input logic [7:0] b);
    send(b, 0);
    chk("R2 start low", rel_t[0] - pull_t[0], 3 * BT / 2);
    chk("R2 start period", pull_t[1] - pull_t[0], 2 * BT);
    for (int i = 1; i <= 8; i++) begin
      chk("R3 data low", rel_t[i] - pull_t[i], b[8 - i] ? (2 * BT) / 3 : BT / 3);
      if (i < 8) chk("R3 data period", pull_t[i + 1] - pull_t[i], BT);
    end
    chk("R5 frame length", done_t - pull_t[0], 10 * BT);
    chk("R5 busy after done", int'(tx_busy), 0);
  endtask

  initial begin
    wait_cyc(3);
    chk("R11 reset pull", int'(line_pull), 0);
    chk("R11 reset busy", int'(tx_busy), 0);
    chk("R11 reset valid", int'(rx_valid), 0);
    chk("R11 reset err", int'(rx_err), 0);
    rst_n = 1;
    wait_cyc(5);

    // R1: pulled in the first cycle after the request
    @(negedge clk); tx_data = 8'h81; tx_start = 1;
    @(negedge clk); tx_start = 0;
    chk("R1 busy", int'(tx_busy), 1);
    chk("R1 pull", int'(line_pull), 1);
    wait_cyc(10 * BT + 20);

    timing_frame(8'hA5);
    timing_frame(8'h3C);

    // R3/R8 loopback of every byte value
    for (int v = 0; v < 256; v++) send(8'(v), 0);

    // R6: request while busy ignored
    begin
      int d0;
      send(8'h5A, 1);
      d0 = n_done;
      wait_cyc(300);
      chk("R6 no second frame", n_done - d0, 0);
      chk("R6 idle", int'(tx_busy), 0);
    end

    // R7: short lows ignored, just above the threshold starts a frame
    begin
      int v0, e0;
      v0 = n_valid; e0 = n_err;
      @(negedge clk); drive_bit(BT / 3, BT); wait_cyc(60);
      drive_bit(BT, 2 * BT); wait_cyc(60);
      chk("R7 no valid", n_valid - v0, 0);
      chk("R7 no err", n_err - e0, 0);
      drive_bit(BT + 1, 2 * BT); wait_cyc(80);
      chk("R7 start recognised -> R10 timeout", n_err - e0, 1);
      chk("R7 still no valid", n_valid - v0, 0);
    end

    // R9: peer period drift
    for (int k = 0; k < 4; k++) begin
      int v0, per;
      per = (k % 2 == 0) ? BT - 1 : BT + 1;
      v0 = n_valid;
      ext_frame(8'hC3 ^ 8'(k * 37), per, 8);
      wait_cyc(40);
      chk("R9 valid", n_valid - v0, 1);
      chk("R9 data", int'(last_rx), int'(8'hC3 ^ 8'(k * 37)));
    end

    // R10: truncated frames
    for (int nb = 0; nb < 8; nb++) begin
      int v0, e0;
      v0 = n_valid; e0 = n_err;
      ext_frame(8'hFF, BT, nb);
      wait_cyc(80);
      chk("R10 err", n_err - e0, 1);
      chk("R10 no valid", n_valid - v0, 0);
    end
    begin
      int v0;
      v0 = n_valid;
      ext_frame(8'h6E, BT, 8);
      wait_cyc(40);
      chk("R10 recovery valid", n_valid - v0, 1);
      chk("R10 recovery data", int'(last_rx), 8'h6E);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule